// File: doc/BRIEF.md
# Microcontroller Power Mode Controller

This block sequences a small 8-bit microcontroller core between run, idle and power-down. Software controls it through one 8-bit control register on a simple special-function-register write/read port. From the current state it produces three enables: the CPU clock enable, the peripheral clock enable (interrupt logic, timers, serial port) and the oscillator enable.

A low-power state ends in one of three ways. The first is an enabled interrupt, which is then serviced. The second is a masked interrupt when the recover bit is set; that interrupt is not serviced and execution continues at the next instruction. The third is reset. A separate hard power-down is entered on a falling edge of an external timer pin when software allows it, and it ends when the pin returns high. Every exit reports, in a one-cycle pulse, whether the core should vector to a service routine.

After any power-down, the CPU clock enable stays low until a programmable stabilization count has run out. During that count the oscillator is already running again.

Top module: `pwrmode_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, cpu_clk_en, per_clk_en and osc_en are all 1, and wake_valid is 0.
- R2: In run, a register write stores bit 7 (baud doubling, also driven on baud_double), bit 6 (hard power-down enable), bit 5 (recover enable) and bits 3..2 (two general flags with no hardware effect). Bit 4 always reads 0.
- R3: Writing bit 0 = 1 in run enters idle from the next cycle: cpu_clk_en = 0, per_clk_en = 1, osc_en = 1, and bit 0 reads 1.
- R4: Writing bit 1 = 1 in run enters power-down: all three enables are 0. If bits 1 and 0 are both written as 1, power-down is taken and the register reads bit 1 = 1, bit 0 = 0.
- R5: In idle or power-down, a source that is enabled (irq_req[i] & irq_en[i] & irq_glb_en) ends the state. Bits 1..0 are cleared, and a one-cycle wake_valid pulse is given with wake_isr = 1.
- R6: With bit 5 = 1, a pending source that is not enabled also ends the state, with wake_isr = 0. Source index T2_IDX is excluded from this path.
- R7: With bit 5 = 0 and no enabled source pending, a pending masked source leaves the controller in its low-power state.
- R8: With bit 6 = 1, a falling edge on t1_pin (after a two-flop synchronizer) in run enters hard power-down, with all enables 0. The pin going high ends it with wake_isr = 0. With bit 6 = 0, a falling edge has no effect.
- R9: On leaving either power-down, osc_en returns to 1 at once while cpu_clk_en and per_clk_en stay 0 for stab_cycles + 1 cycles. cpu_clk_en is never 1 while osc_en is 0.
- R10: Register writes made while not in run are ignored.
- R11: A reset of one clock cycle returns the controller from any state to run, with the register at 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sfr_wr | input | 1 | Register write strobe |
| sfr_wdata | input | 8 | Register write data |
| sfr_rdata | output | 8 | Register contents |
| irq_req | input | NIRQ | Pending interrupt sources |
| irq_en | input | NIRQ | Per-source enables |
| irq_glb_en | input | 1 | Global interrupt enable |
| t1_pin | input | 1 | External timer pin |
| stab_cycles | input | STAB_W | Oscillator stabilization count |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| baud_double | output | 1 | Serial baud doubling |
| wake_valid | output | 1 | One-cycle pulse on leaving a low-power state |
| wake_isr | output | 1 | With wake_valid: 1 = service interrupt, 0 = continue |

## Verification
The bench builds the block with NIRQ = 5, T2_IDX = 4 and STAB_W = 8, and drives stab_cycles to 3. This lets it cover every recovery path: the excluded source index can be held pending on its own to show it is ignored, while a masked source at another index wakes the core. The short count makes the full stabilization window fit in a few cycles, so the bench checks the exact cycle when cpu_clk_en rises after both power-down kinds.

// File: rtl/pwrmode_pkg.sv
// Shared types for the power mode controller.
// Assumes: one encoding of sequencer states is used by all submodules.
package pwrmode_pkg;
    typedef enum logic [2:0] {
        PM_RUN    = 3'd0,
        PM_IDLE   = 3'd1,
        PM_PDOWN  = 3'd2,
        PM_HPDOWN = 3'd3,
        PM_STAB   = 3'd4
    } pm_state_e;

    localparam int BIT_SMOD = 7;
    localparam int BIT_HPD  = 6;
    localparam int BIT_RCV  = 5;
    localparam int BIT_PD   = 1;
    localparam int BIT_IDL  = 0;
endpackage

// File: rtl/pm_t1_sync.sv
// Synchronizes the external timer pin and flags its falling edge.
// Assumes: the pin idles high, so the chain resets to 1 to avoid a false edge.
module pm_t1_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic fall
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    // shift the raw pin through the synchronizer and keep the prior value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '1;
            last_q  <= 1'b1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], pin};
            last_q  <= chain_q[STAGES-1];
        end
    end

    // falling edge of the synchronized level
    always_comb fall = last_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/pm_ctrl_reg.sv
// Holds the 8-bit power control register.
// Assumes: wr_en arrives only while the CPU runs, so it never meets hw_clr.
module pm_ctrl_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    input  logic       hw_clr,
    output logic [7:0] reg_q
);
    import pwrmode_pkg::*;

    // software write with power-down priority; hardware clears mode bits on wake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q <= 8'h00;
        end else if (wr_en) begin
            reg_q <= {wdata[7:5], 1'b0, wdata[3:1], wdata[BIT_IDL] & ~wdata[BIT_PD]};
        end else if (hw_clr) begin
            reg_q[BIT_PD]  <= 1'b0;
            reg_q[BIT_IDL] <= 1'b0;
        end
    end

    AST_PD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdata[BIT_PD]) |=> (reg_q[BIT_PD] && !reg_q[BIT_IDL])); // R4
endmodule

// File: rtl/pm_wake_detect.sv
// Level-senses interrupt sources for wakeup; purely combinational so it
// works with no clock running.
// Assumes: T2_IDX < NIRQ; that index never takes the recover path.
module pm_wake_detect #(
    parameter int NIRQ   = 5,
    parameter int T2_IDX = 4
) (
    input  logic [NIRQ-1:0] irq_req,
    input  logic [NIRQ-1:0] irq_en,
    input  logic            irq_glb_en,
    input  logic            rcv_en,
    output logic            wake_en,
    output logic            wake_rcv
);
    localparam logic [NIRQ-1:0] RCV_MASK = ~({{(NIRQ-1){1'b0}}, 1'b1} << T2_IDX);

    logic [NIRQ-1:0] enabled;

    // split pending sources into serviced and recover-only sets
    always_comb begin
        enabled  = irq_en & {NIRQ{irq_glb_en}};
        wake_en  = |(irq_req & enabled);
        wake_rcv = rcv_en & |(irq_req & ~enabled & RCV_MASK);
    end
endmodule

// File: rtl/pm_seq.sv
// Power state sequencer: run, idle, power-down, hard power-down and
// oscillator stabilization; produces clock enables and the wake report.
// Assumes: enter_* pulses come from qualified run-state register writes.
module pm_seq #(
    parameter int STAB_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enter_idl,
    input  logic              enter_pd,
    input  logic              hpd_en,
    input  logic              rcv_en,
    input  logic              t1_fall,
    input  logic              t1_pin,
    input  logic              wake_en,
    input  logic              wake_rcv,
    input  logic [STAB_W-1:0] stab_cycles,
    output logic              hw_clr,
    output logic              cpu_clk_en,
    output logic              per_clk_en,
    output logic              osc_en,
    output logic              wake_valid,
    output logic              wake_isr
);
    import pwrmode_pkg::*;

    pm_state_e         state_q, state_d;
    logic [STAB_W-1:0] cnt_q, cnt_d;
    logic              wake_d, isr_d;

    // next-state, counter and wake report decision
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        wake_d  = 1'b0;
        isr_d   = 1'b0;
        hw_clr  = 1'b0;
        case (state_q)
            PM_RUN: begin
                if (enter_pd)               state_d = PM_PDOWN;
                else if (enter_idl)         state_d = PM_IDLE;
                else if (hpd_en && t1_fall) state_d = PM_HPDOWN;
            end
            PM_IDLE, PM_PDOWN: begin
                if (wake_en || wake_rcv) begin
                    state_d = (state_q == PM_IDLE) ? PM_RUN : PM_STAB;
                    cnt_d   = stab_cycles;
                    wake_d  = 1'b1;
                    isr_d   = wake_en;
                    hw_clr  = 1'b1;
                end
            end
            PM_HPDOWN: begin
                if (t1_pin) begin
                    state_d = PM_STAB;
                    cnt_d   = stab_cycles;
                    wake_d  = 1'b1;
                end
            end
            PM_STAB: begin
                if (cnt_q == '0) state_d = PM_RUN;
                else             cnt_d   = cnt_q - 1'b1;
            end
            default: state_d = PM_RUN;
        endcase
    end

    // state, counter and wake pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= PM_RUN;
            cnt_q      <= '0;
            wake_valid <= 1'b0;
            wake_isr   <= 1'b0;
        end else begin
            state_q    <= state_d;
            cnt_q      <= cnt_d;
            wake_valid <= wake_d;
            wake_isr   <= isr_d;
        end
    end

    // clock enables decoded from the state
    always_comb begin
        cpu_clk_en = (state_q == PM_RUN);
        per_clk_en = (state_q == PM_RUN) || (state_q == PM_IDLE);
        osc_en     = per_clk_en || (state_q == PM_STAB);
    end

    AST_PDOWN_HOLDS_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PM_PDOWN || state_q == PM_HPDOWN) |=> !cpu_clk_en); // R9
    AST_RCV_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_valid && !wake_isr && $past(state_q) != PM_HPDOWN) |-> $past(rcv_en)); // R6
    AST_WAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_valid |=> !wake_valid); // R5
endmodule

// File: rtl/pwrmode_ctrl.sv
// Top of the power mode controller: register, T1 synchronizer, wake
// detection and the state sequencer.
// Assumes: clk is the free-running oscillator in simulation; osc_en tells
// the clock source when it may stop.
module pwrmode_ctrl #(
    parameter int NIRQ        = 5,
    parameter int T2_IDX      = 4,
    parameter int STAB_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sfr_wr,
    input  logic [7:0]        sfr_wdata,
    output logic [7:0]        sfr_rdata,
    input  logic [NIRQ-1:0]   irq_req,
    input  logic [NIRQ-1:0]   irq_en,
    input  logic              irq_glb_en,
    input  logic              t1_pin,
    input  logic [STAB_W-1:0] stab_cycles,
    output logic              cpu_clk_en,
    output logic              per_clk_en,
    output logic              osc_en,
    output logic              baud_double,
    output logic              wake_valid,
    output logic              wake_isr
);
    import pwrmode_pkg::*;

    logic [7:0] reg_q;
    logic       wr_ok, hw_clr, t1_fall, wake_en, wake_rcv;

    // writes only land while the CPU clock runs
    always_comb begin
        wr_ok       = sfr_wr & cpu_clk_en;
        sfr_rdata   = reg_q;
        baud_double = reg_q[BIT_SMOD];
    end

    pm_ctrl_reg u_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_ok), .wdata(sfr_wdata),
        .hw_clr(hw_clr), .reg_q(reg_q)
    );

    pm_t1_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(t1_pin), .fall(t1_fall)
    );

    pm_wake_detect #(.NIRQ(NIRQ), .T2_IDX(T2_IDX)) u_wake (
        .irq_req(irq_req), .irq_en(irq_en), .irq_glb_en(irq_glb_en),
        .rcv_en(reg_q[BIT_RCV]), .wake_en(wake_en), .wake_rcv(wake_rcv)
    );

    pm_seq #(.STAB_W(STAB_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .enter_idl(wr_ok & sfr_wdata[BIT_IDL]), .enter_pd(wr_ok & sfr_wdata[BIT_PD]),
        .hpd_en(reg_q[BIT_HPD]), .rcv_en(reg_q[BIT_RCV]),
        .t1_fall(t1_fall), .t1_pin(t1_pin),
        .wake_en(wake_en), .wake_rcv(wake_rcv), .stab_cycles(stab_cycles),
        .hw_clr(hw_clr), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
        .osc_en(osc_en), .wake_valid(wake_valid), .wake_isr(wake_isr)
    );

    AST_WAKE_CLEARS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_valid |-> (sfr_rdata[1:0] == 2'b00)); // R5
    AST_LOWPWR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_wr && !cpu_clk_en) |=> (sfr_rdata[7:2] == $past(sfr_rdata[7:2]))); // R10
endmodule

// File: tb/pwrmode_ctrl_bench.sv
`timescale 1ns/1ps
module pwrmode_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sfr_wr = 1'b0;
    logic [7:0] sfr_wdata = 8'h00;
    logic [7:0] sfr_rdata;
    logic [4:0] irq_req = '0;
    logic [4:0] irq_en = '0;
    logic       irq_glb_en = 1'b0;
    logic       t1_pin = 1'b1;
    logic [7:0] stab_cycles = 8'd3;
    logic       cpu_clk_en, per_clk_en, osc_en, baud_double, wake_valid, wake_isr;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    logic exp_q[$];

    always #2.5 clk = ~clk;

    pwrmode_ctrl u_pwrmode_ctrl (
        .clk(clk), .rst_n(rst_n), .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata),
        .sfr_rdata(sfr_rdata), .irq_req(irq_req), .irq_en(irq_en),
        .irq_glb_en(irq_glb_en), .t1_pin(t1_pin), .stab_cycles(stab_cycles),
        .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
        .baud_double(baud_double), .wake_valid(wake_valid), .wake_isr(wake_isr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [7:0] d);
        @(negedge clk); sfr_wr = 1'b1; sfr_wdata = d;
        @(negedge clk); sfr_wr = 1'b0;
    endtask

    task automatic expect_wake(input logic isr);
        exp_q.push_back(isr);
    endtask

    task automatic enables(input string req, input logic [2:0] exp);
        check(req, {29'd0, cpu_clk_en, per_clk_en, osc_en}, {29'd0, exp});
    endtask

    // monitor: every wake pulse is matched against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && wake_valid) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL R5 R6 R8 unexpected wake actual=%0h expected=none", wake_isr);
            end else begin
                check("R5 R6 R8 wake kind", {31'd0, wake_isr}, {31'd0, exp_q.pop_front()});
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc >= 100000) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reg", {24'd0, sfr_rdata}, 32'h00);
        enables("R1 enables", 3'b111);
        check("R1 wake", {31'd0, wake_valid}, 0);

        // R2: field storage, bit 4 reads 0, flags have no effect
        write_reg(8'hDC);
        check("R2 reg", {24'd0, sfr_rdata}, 32'hCC);
        check("R2 baud", {31'd0, baud_double}, 1);
        enables("R2 flags no effect", 3'b111);
        write_reg(8'h00);

        // R3: idle
        write_reg(8'h01);
        enables("R3 idle enables", 3'b011);
        check("R3 reg", {24'd0, sfr_rdata}, 32'h01);
        // R10: write in idle ignored
        write_reg(8'h0C);
        check("R10 write ignored", {24'd0, sfr_rdata}, 32'h01);
        // R7: masked source, recover off
        irq_req = 5'b00001;
        repeat (4) @(negedge clk);
        enables("R7 stays idle", 3'b011);
        // R5: enabled source wakes with service
        expect_wake(1'b1);
        irq_en = 5'b00001; irq_glb_en = 1'b1;
        @(negedge clk);
        enables("R5 back to run", 3'b111);
        check("R5 mode cleared", {24'd0, sfr_rdata}, 32'h00);
        irq_req = '0; irq_en = '0; irq_glb_en = 1'b0;

        // R6: recover path, excluded index first
        write_reg(8'h21);
        irq_req = 5'b10000;
        repeat (3) @(negedge clk);
        enables("R6 excluded index ignored", 3'b011);
        expect_wake(1'b0);
        irq_req = 5'b00100;
        @(negedge clk);
        enables("R6 recover to run", 3'b111);
        check("R6 reg", {24'd0, sfr_rdata}, 32'h20);
        irq_req = '0;
        write_reg(8'h00);

        // R4 / R9: power-down and stabilization
        write_reg(8'h02);
        enables("R4 pdown enables", 3'b000);
        check("R4 reg", {24'd0, sfr_rdata}, 32'h02);
        irq_req = 5'b01000;
        repeat (3) @(negedge clk);
        enables("R7 stays pdown", 3'b000);
        expect_wake(1'b1);
        irq_en = 5'b01000; irq_glb_en = 1'b1;
        @(negedge clk);
        enables("R9 stab first cycle", 3'b001);
        check("R5 pd cleared", {24'd0, sfr_rdata}, 32'h00);
        irq_req = '0; irq_en = '0; irq_glb_en = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            enables("R9 stab hold", 3'b001);
        end
        @(negedge clk);
        enables("R9 run after stab", 3'b111);

        // R4: both bits, power-down wins; R11: short reset
        write_reg(8'h03);
        check("R4 both bits reg", {24'd0, sfr_rdata}, 32'h02);
        enables("R4 both bits enables", 3'b000);
        rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        enables("R11 reset to run", 3'b111);
        check("R11 reg", {24'd0, sfr_rdata}, 32'h00);

        // R8: hard power-down
        write_reg(8'h40);
        t1_pin = 1'b0;
        repeat (5) @(negedge clk);
        enables("R8 hard pdown", 3'b000);
        expect_wake(1'b0);
        t1_pin = 1'b1;
        @(negedge clk);
        enables("R8 R9 exit to stab", 3'b001);
        repeat (3) @(negedge clk);
        enables("R9 hpd stab hold", 3'b001);
        @(negedge clk);
        enables("R8 run", 3'b111);
        write_reg(8'h00);
        t1_pin = 1'b0;
        repeat (5) @(negedge clk);
        enables("R8 edge ignored", 3'b111);
        t1_pin = 1'b1;
        repeat (4) @(negedge clk);

        check("R5 R6 R8 queue drained", exp_q.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule